// File: doc/BRIEF.md
# Slave Serial Configuration Loader

This block configures a target programmable device over a one-bit serial configuration link. A host stages a byte count on `total_i` and pulses `start_i`. The block then drives the target's program request and waits for the target to show its init indication. After a programmable settling delay it releases the program request and waits for the init indication to clear.

Once the target is ready, the block pulls bytes from a valid/ready stream. It shifts each byte out on a data line, most significant bit first, and generates a serial clock whose low and high levels each last a set number of system clock cycles. Before taking each byte it looks at the target's init and done lines. If init is active while done is still low, the target is signalling a checksum error, and the load stops.

After the last byte, the block holds the data line high and keeps pulsing the serial clock until the target raises done. The result is reported on one of three sticky flags: success, checksum error or timeout. All three are cleared when the next load is accepted.

Top module: `serial_cfg_loader`

## Requirements
- R1: When idle, a `start_i` pulse is accepted at the next clock edge. From the following cycle `busy_o` and `cfg_prog_o` are high, and `total_i` is latched as the load length.
- R2: `cfg_prog_o` stays high until `cfg_init_i` reads 1. If `cfg_init_i` does not read 1 within `TMO_CYC` cycles, the load ends with `timeout_o`=1 and `cfg_prog_o` released.
- R3: After `cfg_init_i` is seen, `cfg_prog_o` stays high for `PROG_DLY` more cycles and then drops. The block then waits for `cfg_init_i`=0. If that wait lasts `TMO_CYC` cycles, the load ends with `timeout_o`=1 and no byte taken.
- R4: Each byte is sent as 8 bits, bit 7 first. `cfg_dat_o` is set while `cfg_clk_o` is low and held unchanged while it is high, so that each rising edge of `cfg_clk_o` presents one bit.
- R5: Every low level of `cfg_clk_o` lasts exactly `HALF_CYC` system clock cycles, and every high level inside a byte also lasts `HALF_CYC` cycles.
- R6: Before each byte, if `cfg_init_i`=1 and `cfg_done_i`=0, the load stops at once. The block sets `crc_err_o`=1, takes no further byte and drops `busy_o`.
- R7: `s_ready_o` is high only while the shifter is idle and fewer than the latched total have been taken. Exactly the latched number of bytes is accepted from the stream.
- R8: After the last byte, `cfg_dat_o` is 1 at every further rising edge of `cfg_clk_o`. Clock pulses continue until `cfg_done_i`=1, and then `done_o` is set with no further pulse.
- R9: If `cfg_done_i` stays low for `TMO_CYC` cycles of the trailing clocking, the load ends with `timeout_o`=1 and `done_o`=0. At most one of the three result flags is ever set.
- R10: A `start_i` pulse while `busy_o`=1 is ignored: the running load keeps its length and runs to its normal end.
- R11: `done_o`, `crc_err_o` and `timeout_o` keep their value until a new start is accepted, and all three read 0 in the cycle after that acceptance.
- R12: A load length of 0 skips the byte phase and goes straight to the trailing clocking with the data line high.
- R13: After reset, `busy_o`, `s_ready_o`, `cfg_prog_o`, `done_o`, `crc_err_o` and `timeout_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a load (ignored while busy) |
| total_i | input | CNT_W | Number of bytes to send, sampled at start |
| s_data_i | input | 8 | Stream byte |
| s_valid_i | input | 1 | Stream byte valid |
| s_ready_o | output | 1 | Block takes the stream byte this cycle |
| cfg_prog_o | output | 1 | Program request to the target, active high |
| cfg_clk_o | output | 1 | Serial configuration clock |
| cfg_dat_o | output | 1 | Serial configuration data |
| cfg_init_i | input | 1 | Target init indication, 1 = active |
| cfg_done_i | input | 1 | Target done indication, 1 = done |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Last load finished with done seen |
| crc_err_o | output | 1 | Last load stopped on a checksum error |
| timeout_o | output | 1 | Last load ended on a timeout |

## Verification
The bench builds the block with `HALF_CYC`=2, `PROG_DLY`=3, `TMO_CYC`=40 and `CNT_W`=8. The two-cycle clock levels keep a multi-byte load within a few hundred cycles while still checking that each level lasts exactly `HALF_CYC` cycles. The forty-cycle timeout lets the bench drive all three waits (init assert, init release and done) to expiry without a long run. A small behavioural target model answers the handshake. It collects every bit at the rising serial-clock edges, can raise init partway through the stream, and raises done after a chosen number of edges.

// File: rtl/cfg_ser_pkg.sv
package cfg_ser_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PROG    = 3'd1,
    ST_PDLY    = 3'd2,
    ST_INITCLR = 3'd3,
    ST_FETCH   = 3'd4,
    ST_SHIFT   = 3'd5,
    ST_CLKOUT  = 3'd6
  } cfg_st_e;

  // next byte image after one bit has left from the top
  function automatic logic [7:0] cfg_shl(input logic [7:0] b);
    return {b[6:0], 1'b0};
  endfunction

  // target reports a checksum problem: init active while not yet done
  function automatic logic cfg_crc_flag(input logic init_act, input logic done_hi);
    return init_act & ~done_hi;
  endfunction

  // true when another byte may still be taken
  function automatic logic cfg_more(input logic [31:0] sent, input logic [31:0] total);
    return sent < total;
  endfunction

endpackage

// File: rtl/cfg_timer.sv
module cfg_timer #(
  parameter int LIMIT = 16,
  localparam int TW = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic expired_o
);

  logic [TW-1:0] cnt_q;

  assign expired_o = (cnt_q == TW'(LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (en_i && !expired_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/cfg_bit_shifter.sv
module cfg_bit_shifter import cfg_ser_pkg::*; #(
  parameter int HALF_CYC = 4,
  localparam int HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic       single_i,
  input  logic [7:0] byte_i,
  output logic       active_o,
  output logic       last_o,
  output logic       sclk_o,
  output logic       sdat_o
);

  logic          act_q;
  logic          ph_q;     // 0: clock low phase, 1: clock high phase
  logic [HW-1:0] hcnt_q;
  logic [2:0]    bit_q;
  logic [7:0]    sh_q;
  logic          sclk_q;
  logic          sdat_q;
  logic          half_end;

  assign half_end = (hcnt_q == HW'(HALF_CYC - 1));
  assign active_o = act_q;
  assign last_o   = act_q && ph_q && half_end && (bit_q == 3'd7);
  assign sclk_o   = sclk_q;
  assign sdat_o   = sdat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      ph_q   <= 1'b0;
      hcnt_q <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      sclk_q <= 1'b0;
      sdat_q <= 1'b0;
    end else if (go_i && !act_q) begin
      act_q  <= 1'b1;
      ph_q   <= 1'b0;
      hcnt_q <= '0;
      bit_q  <= single_i ? 3'd7 : 3'd0;
      sh_q   <= byte_i;
      sclk_q <= 1'b0;
      sdat_q <= byte_i[7];
    end else if (act_q) begin
      if (!half_end) begin
        hcnt_q <= hcnt_q + 1'b1;
      end else begin
        hcnt_q <= '0;
        if (!ph_q) begin
          sclk_q <= 1'b1;
          ph_q   <= 1'b1;
        end else if (bit_q == 3'd7) begin
          act_q <= 1'b0;
        end else begin
          bit_q  <= bit_q + 1'b1;
          sh_q   <= cfg_shl(sh_q);
          sdat_q <= sh_q[6];
          sclk_q <= 1'b0;
          ph_q   <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader import cfg_ser_pkg::*; #(
  parameter int CNT_W    = 16,
  parameter int HALF_CYC = 4,
  parameter int PROG_DLY = 16,
  parameter int TMO_CYC  = 1250000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] total_i,
  input  logic [7:0]       s_data_i,
  input  logic             s_valid_i,
  output logic             s_ready_o,
  output logic             cfg_prog_o,
  output logic             cfg_clk_o,
  output logic             cfg_dat_o,
  input  logic             cfg_init_i,
  input  logic             cfg_done_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             crc_err_o,
  output logic             timeout_o
);

  cfg_st_e          st_q, st_d;
  logic [CNT_W-1:0] tot_q, sent_q;
  logic             done_q, crc_q, tmo_q;

  logic       sh_active, sh_last, sh_go, sh_single;
  logic [7:0] sh_byte;
  logic       wait_exp, dly_exp, st_change, wait_en, dly_en;
  logic       start_acc, crc_hit, more_left, byte_take, pulse_go;
  logic       set_done, set_crc, set_tmo;

  assign busy_o    = (st_q != ST_IDLE) || sh_active;
  assign start_acc = start_i && !busy_o;
  assign crc_hit   = cfg_crc_flag(cfg_init_i, cfg_done_i);
  assign more_left = cfg_more(32'(sent_q), 32'(tot_q));
  assign s_ready_o = (st_q == ST_FETCH) && more_left && !crc_hit;
  assign byte_take = s_ready_o && s_valid_i;
  assign pulse_go  = (st_q == ST_CLKOUT) && !cfg_done_i && !wait_exp && !sh_active;

  assign sh_go     = byte_take || pulse_go;
  assign sh_single = pulse_go;
  assign sh_byte   = pulse_go ? 8'hFF : s_data_i;

  assign cfg_prog_o = (st_q == ST_PROG) || (st_q == ST_PDLY);
  assign st_change  = (st_q != st_d);
  assign wait_en    = (st_q == ST_PROG) || (st_q == ST_INITCLR) || (st_q == ST_CLKOUT);
  assign dly_en     = (st_q == ST_PDLY);

  assign done_o    = done_q;
  assign crc_err_o = crc_q;
  assign timeout_o = tmo_q;

  cfg_timer #(.LIMIT(TMO_CYC)) u_wait_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (st_change),
    .en_i     (wait_en),
    .expired_o(wait_exp)
  );

  cfg_timer #(.LIMIT(PROG_DLY)) u_dly_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (st_change),
    .en_i     (dly_en),
    .expired_o(dly_exp)
  );

  cfg_bit_shifter #(.HALF_CYC(HALF_CYC)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (sh_go),
    .single_i(sh_single),
    .byte_i  (sh_byte),
    .active_o(sh_active),
    .last_o  (sh_last),
    .sclk_o  (cfg_clk_o),
    .sdat_o  (cfg_dat_o)
  );

  always_comb begin
    st_d     = st_q;
    set_done = 1'b0;
    set_crc  = 1'b0;
    set_tmo  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_acc) st_d = ST_PROG;
      end
      ST_PROG: begin
        if (cfg_init_i) begin
          st_d = ST_PDLY;
        end else if (wait_exp) begin
          st_d    = ST_IDLE;
          set_tmo = 1'b1;
        end
      end
      ST_PDLY: begin
        if (dly_exp) st_d = ST_INITCLR;
      end
      ST_INITCLR: begin
        if (!cfg_init_i) begin
          st_d = ST_FETCH;
        end else if (wait_exp) begin
          st_d    = ST_IDLE;
          set_tmo = 1'b1;
        end
      end
      ST_FETCH: begin
        if (!more_left) begin
          st_d = ST_CLKOUT;
        end else if (crc_hit) begin
          st_d    = ST_IDLE;
          set_crc = 1'b1;
        end else if (s_valid_i) begin
          st_d = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (sh_last) st_d = ST_FETCH;
      end
      ST_CLKOUT: begin
        if (cfg_done_i) begin
          st_d     = ST_IDLE;
          set_done = 1'b1;
        end else if (wait_exp) begin
          st_d    = ST_IDLE;
          set_tmo = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      tot_q  <= '0;
      sent_q <= '0;
      done_q <= 1'b0;
      crc_q  <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (start_acc) begin
        tot_q  <= total_i;
        sent_q <= '0;
        done_q <= 1'b0;
        crc_q  <= 1'b0;
        tmo_q  <= 1'b0;
      end else begin
        if (byte_take) sent_q <= sent_q + 1'b1;
        if (set_done)  done_q <= 1'b1;
        if (set_crc)   crc_q  <= 1'b1;
        if (set_tmo)   tmo_q  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cfg_loader_checker.sv
module cfg_loader_checker import cfg_ser_pkg::*; #(
  parameter int CNT_W    = 16,
  parameter int HALF_CYC = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_i,
  input logic             done_i,
  input logic             crc_i,
  input logic             tmo_i,
  input logic             ready_i,
  input logic             cclk_i,
  input logic             cdat_i,
  input cfg_st_e          st_i,
  input logic             sh_act_i,
  input logic [CNT_W-1:0] tot_i,
  input logic [CNT_W-1:0] sent_i
);

  logic [15:0] lo_cnt;
  logic        prev_clk;
  logic        armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt   <= '0;
      prev_clk <= 1'b0;
      armed    <= 1'b0;
    end else begin
      prev_clk <= cclk_i;
      armed    <= armed | (prev_clk & ~cclk_i);
      if (cclk_i)                lo_cnt <= '0;
      else if (lo_cnt != 16'hFFFF) lo_cnt <= lo_cnt + 1'b1;
    end
  end

  // R4: data does not move while the serial clock stays high
  a_r4_dat_hold_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cclk_i && prev_clk) |-> $stable(cdat_i));

  // R5: measured low level equals the parameter
  a_r5_low_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cclk_i && !prev_clk && armed) |-> (lo_cnt == 16'(HALF_CYC)));

  // R6: a checksum stop leaves the block idle and not taking bytes
  a_r6_crc_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(crc_i) |-> (!ready_i && !busy_i));

  // R7: stream is only taken while the shifter is free
  a_r7_ready_shifter_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |-> !sh_act_i);

  // R7: never more bytes than requested
  a_r7_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sent_i <= tot_i);

  // R8: trailing pulses carry a high data line
  a_r8_tail_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_CLKOUT && cclk_i && !prev_clk) |-> cdat_i);

  // R9: one outcome per load
  a_r9_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({done_i, crc_i, tmo_i}) <= 1);

  // R10: a start while busy leaves the latched length alone
  a_r10_len_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && start_i) |=> $stable(tot_i));

  // R11: accepted start clears every result flag
  a_r11_flags_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i) |=> (busy_i && !done_i && !crc_i && !tmo_i));

endmodule

bind serial_cfg_loader cfg_loader_checker #(
  .CNT_W   (CNT_W),
  .HALF_CYC(HALF_CYC)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_i  (busy_o),
  .done_i  (done_o),
  .crc_i   (crc_err_o),
  .tmo_i   (timeout_o),
  .ready_i (s_ready_o),
  .cclk_i  (cfg_clk_o),
  .cdat_i  (cfg_dat_o),
  .st_i    (st_q),
  .sh_act_i(sh_active),
  .tot_i   (tot_q),
  .sent_i  (sent_q)
);

// File: tb/test_serial_cfg_loader.sv
module test_serial_cfg_loader;

  localparam int HALF = 2;
  localparam int PDLY = 3;
  localparam int TMO  = 40;
  localparam int CW   = 8;
  localparam int NV   = 4;
  // fields: [23:16] byte count, [15:8] seed, [7:0] trailing pulses
  localparam logic [23:0] VEC [NV] = '{24'h035A02, 24'h018100, 24'h063C04, 24'h02FF01};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          start = 1'b0;
  logic [CW-1:0] total = '0;
  logic          src_en = 1'b0;
  logic [7:0]    s_data;
  logic          s_ready, prog, cclk, cdat, busy, done_f, crc_f, tmo_f;

  int checks = 0;
  int errors = 0;

  int no_init = 0, hold_init = 0, crc_at = 0, done_at = 1000000, exp_n = 0;
  logic [7:0] src_seed = 8'h00;
  logic mdl_clr = 1'b0;

  logic init_q = 1'b0, done_q = 1'b0, prev_c = 1'b0, armed = 1'b0, crc_on = 1'b0;
  int edges = 0, bad_tail = 0, lo_run = 0, lo_bad = 0, pc = 0, rc = 0, src_idx = 0;
  logic [7:0] rx [16];

  function automatic logic [7:0] gen(input logic [7:0] s, input int i);
    return s ^ 8'((i * 29 + 7) & 255);
  endfunction

  assign s_data = gen(src_seed, src_idx);

  serial_cfg_loader #(
    .CNT_W(CW), .HALF_CYC(HALF), .PROG_DLY(PDLY), .TMO_CYC(TMO)
  ) i_serial_cfg_loader (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .total_i(total),
    .s_data_i(s_data), .s_valid_i(src_en), .s_ready_o(s_ready),
    .cfg_prog_o(prog), .cfg_clk_o(cclk), .cfg_dat_o(cdat),
    .cfg_init_i(init_q), .cfg_done_i(done_q),
    .busy_o(busy), .done_o(done_f), .crc_err_o(crc_f), .timeout_o(tmo_f)
  );

  // target model and stream source
  always @(posedge clk) begin
    if (mdl_clr) begin
      init_q <= 1'b0; done_q <= 1'b0; edges <= 0; bad_tail <= 0;
      lo_run <= 0; lo_bad <= 0; pc <= 0; rc <= 0; prev_c <= cclk;
      armed <= 1'b0; crc_on <= 1'b0; src_idx <= 0;
    end else begin
      prev_c <= cclk;
      if (s_ready && src_en) src_idx <= src_idx + 1;
      if (prog) begin
        pc <= pc + 1;
        rc <= 0;
        if (pc == 2 && no_init == 0) init_q <= 1'b1;
      end else begin
        pc <= 0;
        if (init_q && !crc_on) begin
          rc <= rc + 1;
          if (rc == 3 && hold_init == 0) init_q <= 1'b0;
        end
      end
      if (!cclk) lo_run <= lo_run + 1; else lo_run <= 0;
      if (prev_c && !cclk) armed <= 1'b1;
      if (cclk && !prev_c) begin
        if (armed && lo_run != HALF) lo_bad <= lo_bad + 1;
        edges <= edges + 1;
        if (edges < 8 * exp_n) rx[edges / 8][7 - (edges % 8)] <= cdat;
        else if (!cdat) bad_tail <= bad_tail + 1;
        if (edges + 1 == crc_at) begin
          init_q <= 1'b1;
          crc_on <= 1'b1;
        end
        if (edges + 1 >= done_at) done_q <= 1'b1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setup(input int n, input logic [7:0] seed, input int d_at,
                       input int c_at, input int ni, input int hi);
    @(negedge clk);
    exp_n = n; src_seed = seed; done_at = d_at; crc_at = c_at;
    no_init = ni; hold_init = hi; total = CW'(n); src_en = 1'b1;
    mdl_clr = 1'b1;
    @(negedge clk);
    mdl_clr = 1'b0;
  endtask

  task automatic kick();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1 busy after start", int'(busy), 1);
    chk("R1 prog after start", int'(prog), 1);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 5000; k++) begin
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1 (run did not complete)");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R13: reset state
    repeat (3) @(negedge clk);
    chk("R13 busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 busy", int'(busy), 0);
    chk("R13 ready", int'(s_ready), 0);
    chk("R13 prog", int'(prog), 0);
    chk("R13 flags", int'({done_f, crc_f, tmo_f}), 0);

    // vector loop: R4 R5 R7 R8
    for (int v = 0; v < NV; v++) begin
      int n, ex;
      logic [7:0] sd;
      n  = int'(VEC[v][23:16]);
      sd = VEC[v][15:8];
      ex = int'(VEC[v][7:0]);
      setup(n, sd, 8 * n + ex, 0, 0, 0);
      kick();
      wait_idle();
      chk("R8 done flag", int'(done_f), 1);
      chk("R9 no timeout", int'(tmo_f), 0);
      chk("R6 no crc", int'(crc_f), 0);
      chk("R7 bytes taken", src_idx, n);
      chk("R8 edge count", edges, 8 * n + ex);
      chk("R8 tail data high", bad_tail, 0);
      chk("R5 low width", lo_bad, 0);
      for (int i = 0; i < n; i++) chk("R4 byte msb first", int'(rx[i]), int'(gen(sd, i)));
    end

    // R12: zero length
    setup(0, 8'h00, 3, 0, 0, 0);
    kick();
    wait_idle();
    chk("R12 done", int'(done_f), 1);
    chk("R12 edges", edges, 3);
    chk("R12 no bytes", src_idx, 0);
    chk("R12 tail high", bad_tail, 0);

    // R2: init never asserts
    setup(1, 8'h00, 9, 0, 1, 0);
    kick();
    wait_idle();
    chk("R2 timeout", int'(tmo_f), 1);
    chk("R2 prog released", int'(prog), 0);
    chk("R2 no edges", edges, 0);
    chk("R2 no done", int'(done_f), 0);

    // R3: init never clears
    setup(1, 8'h00, 9, 0, 0, 1);
    kick();
    wait_idle();
    chk("R3 timeout", int'(tmo_f), 1);
    chk("R3 no bytes", src_idx, 0);
    chk("R3 no edges", edges, 0);

    // R6: checksum error after two bytes
    setup(6, 8'hC3, 1000000, 16, 0, 0);
    kick();
    wait_idle();
    chk("R6 crc flag", int'(crc_f), 1);
    chk("R6 no done", int'(done_f), 0);
    chk("R6 no timeout", int'(tmo_f), 0);
    chk("R6 bytes taken", src_idx, 2);
    chk("R6 edges", edges, 16);
    chk("R6 ready low", int'(s_ready), 0);
    chk("R6 byte0", int'(rx[0]), int'(gen(8'hC3, 0)));
    chk("R6 byte1", int'(rx[1]), int'(gen(8'hC3, 1)));

    // R11: flags held, then cleared by a new start
    setup(1, 8'h11, 9, 0, 0, 0);
    chk("R11 crc held before start", int'(crc_f), 1);
    kick();
    chk("R11 crc cleared", int'(crc_f), 0);
    wait_idle();
    chk("R11 new load done", int'(done_f), 1);

    // R9: done never rises
    setup(2, 8'h42, 1000000, 0, 0, 0);
    kick();
    wait_idle();
    chk("R9 timeout", int'(tmo_f), 1);
    chk("R9 no done", int'(done_f), 0);
    chk("R9 tail high", bad_tail, 0);
    chk("R9 pulses issued", int'(edges > 16), 1);

    // R10: restart attempt mid-load
    setup(4, 8'h77, 33, 0, 0, 0);
    kick();
    for (int k = 0; k < 2000; k++) begin
      if (src_idx >= 2) break;
      @(negedge clk);
    end
    total = CW'(1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 still busy", int'(busy), 1);
    wait_idle();
    chk("R10 bytes taken", src_idx, 4);
    chk("R10 edges", edges, 33);
    chk("R10 done", int'(done_f), 1);
    for (int i = 0; i < 4; i++) chk("R10 byte", int'(rx[i]), int'(gen(8'h77, i)));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule